// File: doc/BRIEF.md
# Triple Dual-DAC Threshold Loader

This block keeps the six 12-bit threshold codes of a three-channel pulse-height window discriminator, one lower and one upper code per channel. The codes are written and read through a small host register port. Each channel's pair of codes feeds one dual serial DAC. When any code of a channel changes, the block sends that DAC a single 24-clock frame on a shared serial clock and data line. The frame is framed by the DAC's own active-low select, and only one select is low at a time.

A write that arrives while another frame is being sent is not lost. It marks its DAC as pending. Pending DACs are served one frame at a time, lowest DAC index first. A busy flag covers the whole period from the first pending request to the end of the last frame. After reset every code is zero and each of the three DACs is loaded once without any host action.

The serial clock runs at the system clock divided by the even parameter `SCLK_DIV`, which defaults to 4. Each frame therefore takes `(4*CODE_W+2)*SCLK_DIV/2` system cycles.

Top module: `thr_dac_loader`

## Requirements
- R1: After reset all six codes read as zero, `busy` is high, and DACs 0, 1 and 2 are each loaded once in that order with an all-zero frame.
- R2: A write to register address `2*d` sets the lower code of channel `d`, and a write to `2*d+1` sets its upper code (d = 0..2). `rd_data` shows the code at `rd_addr` in the same cycle.
- R3: Writes to addresses 6 and 7 change no code and start no frame. Reads of those addresses return zero.
- R4: A frame carries exactly 24 rising serial-clock edges, MSB first: the 12-bit upper code, then the 12-bit lower code.
- R5: `dac_din` changes only while `dac_sclk` is low, so it is stable at every rising edge.
- R6: A DAC select falls half a serial-clock period before the first rising edge. It rises one full period after the 24th rising edge.
- R7: At most one bit of `dac_cs_n` is low at any time, and the low bit is the index of the DAC being loaded.
- R8: Consecutive rising serial-clock edges within a frame are `SCLK_DIV` system cycles apart.
- R9: Writes that land during a frame are queued per DAC. Afterwards the queued DACs are loaded one per frame in ascending index order.
- R10: A write to the DAC whose frame is in progress causes one more frame to that DAC, carrying the new code.
- R11: `busy` is high whenever a frame is in progress or any DAC is pending, and low otherwise.
- R12: While no frame is in progress, all selects are high and `dac_sclk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address (2*channel + upper) |
| wr_data | input | 12 | Threshold code to write |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 12 | Code at `rd_addr`, zero for unused addresses |
| busy | output | 1 | A frame is running or a DAC is pending |
| dac_sclk | output | 1 | Shared serial clock to the DACs |
| dac_din | output | 1 | Shared serial data to the DACs |
| dac_cs_n | output | 3 | Active-low select, one per dual DAC |

## Verification
The bench writes the upper code of a channel and then, once that frame has started, the lower code of the same channel. A design that dropped a write aimed at the DAC being loaded would send one stale frame and never the second. Two writes to channels 0 and 2 land in the middle of a channel-2 frame. An arbiter that served them in arrival order, or cleared a pending bit on the wrong edge, would emit the frames in the wrong order or merge them. The bench also measures select-to-edge spacing and edge-to-edge spacing in system cycles, and counts rising edges per frame. A frame that was one bit short or long, or a select released too early, shows up directly in those counts.

// File: rtl/thr_pkg.sv
package thr_pkg;

    typedef enum logic {
        SER_IDLE = 1'b0,
        SER_RUN  = 1'b1
    } ser_state_e;

endpackage

// File: rtl/thr_regfile.sv
module thr_regfile #(
    parameter int CODE_W = 12,
    parameter int N_DAC  = 3,
    parameter int ADDR_W = 3
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [ADDR_W-1:0]                    wr_addr,
    input  logic [CODE_W-1:0]                    wr_data,
    input  logic [ADDR_W-1:0]                    rd_addr,
    output logic [CODE_W-1:0]                    rd_data,
    output logic [N_DAC-1:0][2*CODE_W-1:0]       frames,
    output logic [N_DAC-1:0]                     wr_hit
);
    localparam int N_REG = 2 * N_DAC;

    typedef struct packed {
        logic [N_REG-1:0][CODE_W-1:0] regs;
    } rf_t;

    rf_t st_d, st_q;

    // Write decode: even address is the lower code, odd the upper code.
    always_comb begin
        st_d   = st_q;
        wr_hit = '0;
        for (int i = 0; i < N_REG; i++) begin
            if (wr_en && wr_addr == ADDR_W'(i)) begin
                st_d.regs[i] = wr_data;
                wr_hit[i/2]  = 1'b1;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_REG; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                rd_data = st_q.regs[i];
            end
        end
    end

    // Frame word per DAC: upper code in the high half, sent first.
    for (genvar d = 0; d < N_DAC; d++) begin : g_frame
        assign frames[d] = {st_q.regs[2*d+1], st_q.regs[2*d]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/thr_arbiter.sv
module thr_arbiter #(
    parameter int N_DAC = 3,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DAC-1:0] set_req,
    input  logic             grant_en,
    output logic             grant_valid,
    output logic [IDX_W-1:0] grant_idx,
    output logic [N_DAC-1:0] pending
);
    typedef struct packed {
        logic [N_DAC-1:0] pend;
    } arb_t;

    arb_t st_d, st_q;
    logic found;

    // Lowest pending index wins; a new request beats a same-cycle clear.
    always_comb begin
        st_d        = st_q;
        found       = 1'b0;
        grant_idx   = '0;
        for (int i = 0; i < N_DAC; i++) begin
            if (!found && st_q.pend[i]) begin
                found     = 1'b1;
                grant_idx = IDX_W'(i);
            end
        end
        grant_valid = found && grant_en;
        if (grant_valid) begin
            for (int i = 0; i < N_DAC; i++) begin
                if (grant_idx == IDX_W'(i)) begin
                    st_d.pend[i] = 1'b0;
                end
            end
        end
        st_d.pend = st_d.pend | set_req;
    end

    assign pending = st_q.pend;

    // Reset leaves every DAC pending so each is loaded once.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend <= '1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/thr_serializer.sv
module thr_serializer
    import thr_pkg::*;
#(
    parameter int N_DAC    = 3,
    parameter int FRAME_W  = 24,
    parameter int SCLK_DIV = 4,
    parameter int IDX_W    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [IDX_W-1:0]   start_idx,
    input  logic [FRAME_W-1:0] start_word,
    output logic               active,
    output logic               sclk,
    output logic               din,
    output logic [N_DAC-1:0]   cs_n
);
    localparam int HALF      = SCLK_DIV / 2;
    localparam int DIV_W     = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int HP_LAST_R = 2 * FRAME_W - 1;   // half period of the last rise
    localparam int HP_FALL   = 2 * FRAME_W;       // final falling edge
    localparam int HP_CS_OFF = 2 * FRAME_W + 1;   // select released
    localparam int HP_DONE   = 2 * FRAME_W + 2;   // frame over
    localparam int HP_W      = $clog2(HP_DONE + 1);

    typedef struct packed {
        ser_state_e         state;
        logic [DIV_W-1:0]   div;
        logic [HP_W-1:0]    hp;
        logic [FRAME_W-1:0] shreg;
        logic               sclk;
        logic               din;
        logic [N_DAC-1:0]   cs_n;
    } ser_t;

    ser_t st_d, st_q;
    logic [HP_W-1:0] nh;

    always_comb begin
        st_d = st_q;
        nh   = st_q.hp + 1'b1;
        case (st_q.state)
            SER_IDLE: begin
                if (start) begin
                    st_d.state = SER_RUN;
                    st_d.div   = '0;
                    st_d.hp    = '0;
                    st_d.shreg = start_word;
                    st_d.din   = start_word[FRAME_W-1];
                    st_d.sclk  = 1'b0;
                    for (int i = 0; i < N_DAC; i++) begin
                        st_d.cs_n[i] = (start_idx != IDX_W'(i));
                    end
                end
            end
            SER_RUN: begin
                if (st_q.div == DIV_W'(HALF - 1)) begin
                    st_d.div = '0;
                    st_d.hp  = nh;
                    if (nh == HP_W'(HP_DONE)) begin
                        st_d.state = SER_IDLE;
                        st_d.hp    = '0;
                    end else if (nh == HP_W'(HP_CS_OFF)) begin
                        st_d.cs_n = '1;
                    end else if (nh[0]) begin
                        st_d.sclk = 1'b1;
                    end else begin
                        st_d.sclk = 1'b0;
                        if (nh < HP_W'(HP_FALL)) begin
                            st_d.shreg = {st_q.shreg[FRAME_W-2:0], 1'b0};
                            st_d.din   = st_q.shreg[FRAME_W-2];
                        end
                    end
                end else begin
                    st_d.div = st_q.div + 1'b1;
                end
            end
            default: st_d.state = SER_IDLE;
        endcase
    end

    assign active = (st_q.state == SER_RUN);
    assign sclk   = st_q.sclk;
    assign din    = st_q.din;
    assign cs_n   = st_q.cs_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= SER_IDLE;
            st_q.div   <= '0;
            st_q.hp    <= '0;
            st_q.shreg <= '0;
            st_q.sclk  <= 1'b0;
            st_q.din   <= 1'b0;
            st_q.cs_n  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // The last rise index must fit the half-period counter.
    initial begin
        if (HP_LAST_R >= HP_DONE || SCLK_DIV < 2 || (SCLK_DIV % 2) != 0) begin
            $display("thr_serializer: SCLK_DIV must be even and at least 2");
        end
    end

endmodule

// File: rtl/thr_dac_loader.sv
module thr_dac_loader #(
    parameter  int CODE_W   = 12,
    parameter  int N_DAC    = 3,
    parameter  int SCLK_DIV = 4,
    localparam int ADDR_W   = $clog2(2 * N_DAC),
    localparam int IDX_W    = (N_DAC > 1) ? $clog2(N_DAC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CODE_W-1:0] rd_data,
    output logic              busy,
    output logic              dac_sclk,
    output logic              dac_din,
    output logic [N_DAC-1:0]  dac_cs_n
);
    localparam int FRAME_W = 2 * CODE_W;

    logic [N_DAC-1:0][FRAME_W-1:0] frames;
    logic [N_DAC-1:0]              wr_hit;
    logic [N_DAC-1:0]              pending;
    logic                          grant_valid;
    logic [IDX_W-1:0]              grant_idx;
    logic [FRAME_W-1:0]            grant_word;
    logic                          ser_active;

    thr_regfile #(
        .CODE_W (CODE_W),
        .N_DAC  (N_DAC),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .frames  (frames),
        .wr_hit  (wr_hit)
    );

    thr_arbiter #(
        .N_DAC (N_DAC),
        .IDX_W (IDX_W)
    ) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_req     (wr_hit),
        .grant_en    (!ser_active),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx),
        .pending     (pending)
    );

    always_comb begin
        grant_word = '0;
        for (int i = 0; i < N_DAC; i++) begin
            if (grant_idx == IDX_W'(i)) begin
                grant_word = frames[i];
            end
        end
    end

    thr_serializer #(
        .N_DAC    (N_DAC),
        .FRAME_W  (FRAME_W),
        .SCLK_DIV (SCLK_DIV),
        .IDX_W    (IDX_W)
    ) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (grant_valid),
        .start_idx  (grant_idx),
        .start_word (grant_word),
        .active     (ser_active),
        .sclk       (dac_sclk),
        .din        (dac_din),
        .cs_n       (dac_cs_n)
    );

    assign busy = ser_active | (|pending);

endmodule

// File: rtl/thr_dac_loader_chk.sv
module thr_dac_loader_chk #(
    parameter int N_DAC = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             dac_sclk,
    input logic             dac_din,
    input logic [N_DAC-1:0] dac_cs_n
);

    assert_one_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~dac_cs_n) <= 1);

    assert_idle_clock_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (&dac_cs_n) |-> !dac_sclk);

    assert_data_stable_at_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_sclk) |-> $stable(dac_din));

    assert_select_steady_while_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sclk |-> $stable(dac_cs_n));

    assert_busy_during_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(&dac_cs_n) |-> busy);

    assert_busy_drops_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (&dac_cs_n));

endmodule

bind thr_dac_loader thr_dac_loader_chk #(.N_DAC(N_DAC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .dac_sclk (dac_sclk),
    .dac_din  (dac_din),
    .dac_cs_n (dac_cs_n)
);

// File: tb/thr_dac_loader_tb.sv
module thr_dac_loader_tb;
    localparam int CODE_W    = 12;
    localparam int N_DAC     = 3;
    localparam int SCLK_DIV  = 4;
    localparam int HALF      = SCLK_DIV / 2;
    localparam int FW        = 2 * CODE_W;
    localparam int FRAME_CYC = (2 * FW + 2) * HALF;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n   = 1'b0;
    logic        wr_en   = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [11:0] rd_data;
    logic        busy, dac_sclk, dac_din;
    logic [2:0]  dac_cs_n;

    thr_dac_loader #(.CODE_W(CODE_W), .N_DAC(N_DAC), .SCLK_DIV(SCLK_DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .dac_sclk(dac_sclk),
        .dac_din(dac_din), .dac_cs_n(dac_cs_n)
    );

    int errors = 0;
    int checks = 0;
    bit done_flag = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on every rising clock edge.
    logic [11:0] m_reg [6];
    bit   [2:0]  m_pend;
    bit          m_act;
    int          m_t;
    int          m_dev;
    logic [23:0] m_word;
    int          cyc = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            foreach (m_reg[i]) m_reg[i] = '0;
            m_pend = 3'b111;
            m_act  = 0;
            m_t    = 0;
            m_dev  = 0;
        end else begin
            if (m_act) begin
                m_t++;
                if (m_t == FRAME_CYC) m_act = 0;
            end else if (m_pend != 0) begin
                for (int d = N_DAC - 1; d >= 0; d--) if (m_pend[d]) m_dev = d;
                m_word = {m_reg[2*m_dev+1], m_reg[2*m_dev]};
                m_pend[m_dev] = 0;
                m_act = 1;
                m_t   = 0;
            end
            if (wr_en && wr_addr < 6) begin
                m_reg[wr_addr] = wr_data;
                m_pend[wr_addr/2] = 1;
            end
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            int hp, idx;
            logic [2:0] exp_cs;
            bit exp_sclk;
            hp = m_t / HALF;
            exp_cs   = (m_act && hp <= 2*FW) ? ~(3'b001 << m_dev) : 3'b111;
            exp_sclk = m_act && (hp % 2 == 1) && hp <= 2*FW - 1;
            chk(dac_cs_n == exp_cs, "R7 select", 32'(dac_cs_n), 32'(exp_cs));
            chk(dac_sclk == exp_sclk, "R12 sclk", 32'(dac_sclk), 32'(exp_sclk));
            if (exp_cs != 3'b111) begin
                idx = (hp / 2 > FW - 1) ? FW - 1 : hp / 2;
                chk(dac_din == m_word[FW-1-idx], "R4 din", 32'(dac_din), 32'(m_word[FW-1-idx]));
            end
            chk(busy == (m_act || m_pend != 0), "R11 busy", 32'(busy), 32'(m_act || m_pend != 0));
            chk(rd_data == ((rd_addr < 6) ? m_reg[rd_addr] : 12'h0), "R2 readback",
                32'(rd_data), 32'((rd_addr < 6) ? m_reg[rd_addr] : 12'h0));
        end
    end

    // DAC-side receiver: collects frames and measures edge spacing.
    logic [1:0]  dq_dev  [$];
    logic [23:0] dq_word [$];
    logic [23:0] rx_word = '0;
    int          rx_cnt = 0;
    int          cs_fall_cyc = 0, last_rise_cyc = 0;
    logic        prev_sclk = 1'b0;
    logic [2:0]  prev_cs = 3'b111;

    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            if (prev_cs == 3'b111 && dac_cs_n != 3'b111) cs_fall_cyc = cyc;
            if (dac_cs_n != 3'b111 && dac_sclk && !prev_sclk) begin
                if (rx_cnt == 0)
                    chk(cyc - cs_fall_cyc == HALF, "R6 lead", 32'(cyc - cs_fall_cyc), 32'(HALF));
                else
                    chk(cyc - last_rise_cyc == SCLK_DIV, "R8 period", 32'(cyc - last_rise_cyc), 32'(SCLK_DIV));
                last_rise_cyc = cyc;
                rx_word = {rx_word[22:0], dac_din};
                rx_cnt++;
            end
            if (dac_cs_n == 3'b111 && prev_cs != 3'b111) begin
                chk(rx_cnt == FW, "R4 edge count", 32'(rx_cnt), 32'(FW));
                chk(cyc - last_rise_cyc == SCLK_DIV, "R6 trail", 32'(cyc - last_rise_cyc), 32'(SCLK_DIV));
                for (int i = 0; i < N_DAC; i++) if (!prev_cs[i]) dq_dev.push_back(2'(i));
                dq_word.push_back(rx_word);
                rx_cnt  = 0;
                rx_word = '0;
            end
        end
        prev_sclk = dac_sclk;
        prev_cs   = dac_cs_n;
    end

    task automatic wr(input logic [2:0] a, input logic [11:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
        repeat (4) @(negedge clk);
    endtask

    task automatic expect_frames(input string req, input int n, input logic [1:0] dv [3], input logic [23:0] wd [3]);
        chk(dq_dev.size() == n, req, 32'(dq_dev.size()), 32'(n));
        for (int i = 0; i < n && i < dq_dev.size(); i++) begin
            chk(dq_dev[i] == dv[i], req, 32'(dq_dev[i]), 32'(dv[i]));
            chk(dq_word[i] == wd[i], req, 32'(dq_word[i]), 32'(wd[i]));
        end
        dq_dev.delete();
        dq_word.delete();
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk); #2;
        rst_n = 1'b1;
        // R1: reset state and the automatic load of all three DACs.
        @(negedge clk);
        chk(busy == 1'b1, "R1 busy after reset", 32'(busy), 32'd1);
        for (int a = 0; a < 6; a++) begin
            @(posedge clk); #2; rd_addr = 3'(a);
            @(negedge clk);
            chk(rd_data == 12'h0, "R1 code zero", 32'(rd_data), 32'h0);
        end
        wait_idle();
        expect_frames("R1 boot order", 3, '{2'd0, 2'd1, 2'd2}, '{24'h0, 24'h0, 24'h0});

        // R10: second write lands on the DAC whose frame is running.
        wr(3'd3, 12'hABC);
        wr(3'd2, 12'h123);
        wait_idle();
        expect_frames("R10 reload", 2, '{2'd1, 2'd1, 2'd0}, '{24'hABC000, 24'hABC123, 24'h0});

        // R9: channel 2 frame runs while channels 0 and 2 are written.
        wr(3'd4, 12'hFFF);
        repeat (5) @(posedge clk);
        wr(3'd5, 12'h800);
        wr(3'd1, 12'h5A5);
        wait_idle();
        expect_frames("R9 queue order", 3, '{2'd2, 2'd0, 2'd2}, '{24'h000FFF, 24'h5A5000, 24'h800FFF});

        // R3: unused addresses are ignored.
        wr(3'd6, 12'h777);
        wr(3'd7, 12'h999);
        @(posedge clk); #2; rd_addr = 3'd6;
        repeat (20) @(negedge clk);
        chk(busy == 1'b0, "R3 no busy", 32'(busy), 32'd0);
        chk(rd_data == 12'h0, "R3 read 6", 32'(rd_data), 32'h0);
        expect_frames("R3 no frame", 0, '{2'd0, 2'd0, 2'd0}, '{24'h0, 24'h0, 24'h0});

        // R2: final readback of every code.
        begin
            logic [11:0] exp_codes [6];
            exp_codes = '{12'h000, 12'h5A5, 12'h123, 12'hABC, 12'hFFF, 12'h800};
            for (int a = 0; a < 6; a++) begin
                @(posedge clk); #2; rd_addr = 3'(a);
                @(negedge clk);
                chk(rd_data == exp_codes[a], "R2 final readback", 32'(rd_data), 32'(exp_codes[a]));
            end
        end
        finish_run();
    end

endmodule